// File: doc/BRIEF.md
# Pipelined Task Completion Controller

This block sequences one run of a compute task through a start/done/ready/idle handshake. A start request passes through a register chain whose depth is set by a parameter before the controller sees it. While idle, the controller accepts a start that leaves the end of that chain. It then waits until every child unit reports completion. After that it spends one finishing cycle. Last, it counts out a drain period as long as the register depth and returns to idle.

Completion is reported twice. `ready` pulses in the finishing cycle itself. `done` is the same pulse after it has passed through a second register chain of the same depth. A deep pipeline can therefore take its start and completion through added register stages without changing the controller. The child done flags arrive already delayed through their own chains, so the controller only combines them.

Top module: `task_ctl_top`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, `idle` is 1 and `ready` and `done` are 0.
- R2: A start that is high at a clock edge is seen by the controller STAGES edges later (directly when STAGES is 0). If the controller is idle at that edge, `idle` goes low in the next cycle.
- R3: Once the task is accepted, the controller stays busy until all bits of `child_done` are 1 at the same edge. With zero children it goes on without waiting.
- R4: `ready` is high for exactly one cycle per run, namely the cycle after the edge at which all children were seen done.
- R5: `done` repeats `ready` delayed by exactly STAGES cycles.
- R6: After the `ready` cycle, `idle` stays low for exactly STAGES more cycles and then returns to 1.
- R7: A start that reaches the controller while it is not idle has no effect. No second run follows from it.
- R8: With STAGES equal to 0, `idle` is 1 again in the cycle directly after `ready`, and `done` equals `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request |
| child_done | input | max(1,CHILDREN) | Per-child completion flags, already pipelined |
| idle | output | 1 | Controller is waiting for a start |
| done | output | 1 | Completion pulse delayed by STAGES cycles |
| ready | output | 1 | Completion pulse in the finishing cycle |

## Verification
The bench runs three copies of the block side by side, with pipeline depths 0, 1 and 3, and compares each against a cycle model built from the requirements. The corner cases it targets are these. A start that lands while a run is still draining must be dropped; a design that queued it would start a phantom second run. Children that finish at different times must all be awaited; a design that used OR instead of AND would leave the running state early. At depth 0 the drain phase must vanish and `done` must equal `ready`. At depth 3 the drain must last exactly three cycles, and an off-by-one countdown would show up as `idle` returning one cycle early or late.

// File: rtl/task_ctl_pkg.sv
package task_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_RUN   = 2'b01,
    ST_FIN   = 2'b10,
    ST_DRAIN = 2'b11
  } ctl_state_e;

  // width of the drain counter: enough bits for (stages - 1), at least one
  function automatic int drain_bits(input int stages);
    return (stages <= 1) ? 1 : $clog2(stages);
  endfunction

  // value loaded into the drain counter on leaving the finishing state
  function automatic int drain_load(input int stages);
    return (stages > 0) ? stages - 1 : 0;
  endfunction

  // port width for the child flags, never zero
  function automatic int flag_bits(input int children);
    return (children > 0) ? children : 1;
  endfunction

endpackage

// File: rtl/sig_chain.sv
module sig_chain #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      // each stage is a separate flop cleared by reset
      logic [DEPTH-1:0] stg;
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
          always_ff @(posedge clk) begin
            if (rst) stg[i] <= 1'b0;
            else     stg[i] <= d;
          end
        end else begin : g_tail
          always_ff @(posedge clk) begin
            if (rst) stg[i] <= 1'b0;
            else     stg[i] <= stg[i-1];
          end
        end
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/task_ctl_fsm.sv
module task_ctl_fsm
  import task_ctl_pkg::*;
#(
  parameter int STAGES   = 2,
  parameter int CHILDREN = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_seen,
  input  logic [flag_bits(CHILDREN)-1:0] child_flags,
  output ctl_state_e state
);

  localparam int CW = drain_bits(STAGES);
  localparam logic [CW-1:0] LOADV = CW'(drain_load(STAGES));

  logic          all_done;
  logic [CW-1:0] drain_cnt;
  ctl_state_e    state_nx;
  logic [CW-1:0] cnt_nx;

  generate
    if (CHILDREN == 0) begin : g_nochild
      assign all_done = 1'b1;
    end else begin : g_child
      assign all_done = &child_flags;
    end
  endgenerate

  always_comb begin
    state_nx = state;
    cnt_nx   = drain_cnt;
    unique case (state)
      ST_IDLE:  if (start_seen) state_nx = ST_RUN;
      ST_RUN:   if (all_done)   state_nx = ST_FIN;
      ST_FIN: begin
        state_nx = (STAGES > 0) ? ST_DRAIN : ST_IDLE;
        cnt_nx   = LOADV;
      end
      ST_DRAIN: begin
        if (drain_cnt == '0) state_nx = ST_IDLE;
        else                 cnt_nx   = drain_cnt - CW'(1);
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      drain_cnt <= '0;
    end else begin
      state     <= state_nx;
      drain_cnt <= cnt_nx;
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start_seen) |=> (state == ST_RUN));

  p_wait_children_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !all_done) |=> (state == ST_RUN));

  p_fin_once_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIN) |=> (state != ST_FIN));

  p_drain_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN && drain_cnt == '0) |=> (state == ST_IDLE));

  p_busy_no_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN) |=> (state != ST_RUN));

  generate
    if (STAGES == 0) begin : g_a_nodrain
      p_no_drain_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIN) |=> (state == ST_IDLE));
    end
  endgenerate

endmodule

// File: rtl/task_ctl_top.sv
module task_ctl_top
  import task_ctl_pkg::*;
#(
  parameter int STAGES   = 2,
  parameter int CHILDREN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic [flag_bits(CHILDREN)-1:0] child_done,
  output logic idle,
  output logic done,
  output logic ready
);

  logic       start_seen;
  logic       fin_evt;
  ctl_state_e state;

  sig_chain #(.DEPTH(STAGES)) u_start_chain (
    .clk (clk),
    .rst (rst),
    .d   (start),
    .q   (start_seen)
  );

  task_ctl_fsm #(.STAGES(STAGES), .CHILDREN(CHILDREN)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_seen  (start_seen),
    .child_flags (child_done),
    .state       (state)
  );

  assign fin_evt = (state == ST_FIN);

  sig_chain #(.DEPTH(STAGES)) u_done_chain (
    .clk (clk),
    .rst (rst),
    .d   (fin_evt),
    .q   (done)
  );

  assign idle  = (state == ST_IDLE);
  assign ready = fin_evt;

  p_ready_busy_r4: assert property (@(posedge clk) disable iff (rst)
    ready |-> !idle);

  generate
    if (STAGES > 0) begin : g_a_late
      p_done_in_drain_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !idle);
    end else begin : g_a_same
      p_done_eq_ready_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> ready);
    end
  endgenerate

endmodule

// File: tb/tb_task_ctl_top.sv
module tb_task_ctl_top;

  localparam int NCFG = 3;
  localparam int NCH  = 3;
  localparam int LV [NCFG] = '{0, 1, 3};

  logic clk = 1'b0;
  logic rst;
  logic start;
  logic [NCH-1:0] cdone;
  logic idle_w [NCFG];
  logic done_w [NCFG];
  logic ready_w[NCFG];
  int   chk0 = 0, fail0 = 0;
  string tag = "R1";
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    localparam int L = LV[g];
    logic di, dd, dr;
    int nchk = 0, nfail = 0;
    // reference model state
    int   mph, mleft;
    logic [7:0] sh, rh;

    if (g == 0) begin : g_dut0
      task_ctl_top #(.STAGES(L), .CHILDREN(NCH)) dut (
        .clk(clk), .rst(rst), .start(start), .child_done(cdone),
        .idle(di), .done(dd), .ready(dr));
    end else begin : g_dutn
      task_ctl_top #(.STAGES(L), .CHILDREN(NCH)) dut_n (
        .clk(clk), .rst(rst), .start(start), .child_done(cdone),
        .idle(di), .done(dd), .ready(dr));
    end

    assign idle_w[g]  = di;
    assign done_w[g]  = dd;
    assign ready_w[g] = dr;

    // phases: 0 waiting, 1 working, 2 finishing, 3 draining
    always @(posedge clk) begin
      logic seen;
      if (rst) begin
        mph <= 0; mleft <= 0; sh <= '0; rh <= '0;
      end else begin
        seen = (L == 0) ? start : sh[L-1];
        sh <= {sh[6:0], start};
        rh <= {rh[6:0], (mph == 2)};
        if (mph == 0 && seen)        mph <= 1;
        else if (mph == 1 && &cdone) mph <= 2;
        else if (mph == 2) begin
          mleft <= L;
          mph   <= (L == 0) ? 0 : 3;
        end else if (mph == 3) begin
          if (mleft == 1) mph <= 0;
          mleft <= mleft - 1;
        end
      end
    end

    always @(negedge clk) begin
      logic e_idle, e_ready, e_done;
      if (!rst && !finished) begin
        e_idle  = (mph == 0);
        e_ready = (mph == 2);
        e_done  = (L == 0) ? e_ready : rh[L-1];
        nchk += 3;
        if (di !== e_idle) begin
          nfail++;
          $display("FAIL R2/R6 [%s] L=%0d idle got %0b exp %0b t=%0t", tag, L, di, e_idle, $time);
          if (L == 0) $display("FAIL R8 [%s] idle got %0b exp %0b", tag, di, e_idle);
        end
        if (dr !== e_ready) begin
          nfail++;
          $display("FAIL R3/R4 [%s] L=%0d ready got %0b exp %0b t=%0t", tag, L, dr, e_ready, $time);
        end
        if (dd !== e_done) begin
          nfail++;
          $display("FAIL R5 [%s] L=%0d done got %0b exp %0b t=%0t", tag, L, dd, e_done, $time);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check_all_idle(input string req);
    for (int k = 0; k < NCFG; k++) begin
      chk0++;
      if (idle_w[k] !== 1'b1 || ready_w[k] !== 1'b0 || done_w[k] !== 1'b0) begin
        fail0++;
        $display("FAIL %s cfg %0d idle/ready/done got %0b%0b%0b exp 100", req, k,
                 idle_w[k], ready_w[k], done_w[k]);
      end
    end
  endtask

  task automatic summary();
    int c, f;
    c = chk0 + g_cfg[0].nchk + g_cfg[1].nchk + g_cfg[2].nchk;
    f = fail0 + g_cfg[0].nfail + g_cfg[1].nfail + g_cfg[2].nfail;
    $display("TB_RESULT checks=%0d failures=%0d", c, f);
  endtask

  initial begin
    void'($urandom(32'h1d2c));
    rst = 1'b1; start = 1'b0; cdone = '0;
    cyc(3);
    @(negedge clk);
    check_all_idle("R1");            // while reset held
    rst = 1'b0;
    @(negedge clk);
    check_all_idle("R1");            // first cycle after release
    #1;

    // R3: children finish one by one, run must wait for the last
    tag = "R3";
    start = 1'b1; cyc(1); start = 1'b0;
    cyc(8);
    cdone = 3'b001; cyc(3);
    cdone = 3'b011; cyc(3);
    cdone = 3'b111; cyc(1);
    cdone = '0; cyc(8);

    // R7: restart pulses while busy are dropped
    tag = "R7";
    cdone = '1;
    start = 1'b1; cyc(1); start = 1'b0;
    cyc(2);
    start = 1'b1; cyc(1); start = 1'b0;
    cyc(1);
    start = 1'b1; cyc(1); start = 1'b0;
    cyc(20);
    @(negedge clk);
    check_all_idle("R7");
    #1;

    // R8: back-to-back starts with children always done
    tag = "R8";
    for (int k = 0; k < 12; k++) begin
      start = 1'b1; cyc(1);
    end
    start = 1'b0; cyc(12);

    // random mix
    tag = "rand";
    for (int k = 0; k < 4000; k++) begin
      start = (($urandom % 6) == 0);
      for (int b = 0; b < NCH; b++) cdone[b] = (($urandom % 4) != 0);
      cyc(1);
    end
    start = 1'b0; cdone = '1;
    cyc(20);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fail0++;
      chk0++;
      $display("FAIL watchdog: run did not end, got hang exp completion");
      summary();
      $finish;
    end
  end

endmodule